// File: doc/BRIEF.md
# Protection Configuration Register File

This block stores the setup of a physical memory protection unit that has a fixed number of entries. Each entry has one configuration byte and one address register. The core reaches these through a single register port. A request names a register class (configuration or address) and an index, and carries write data or asks for a read. Configuration registers are XLEN bits wide. Each one packs XLEN/8 consecutive entry bytes. The block unpacks a written word into bytes and packs the bytes back into a word on a read.

Lock rules decide which writes are allowed. An entry whose own lock bit is set cannot be changed. An entry is also frozen when the entry directly above it is locked and uses top-of-range matching. In that mode the lower entry's address acts as the base of the upper entry's range. A frozen entry silently keeps its value. A write that loses any part of its content pulses a drop flag one cycle later. The causes are a lock, an index past the last entry, or an odd configuration index when XLEN is 64.

The block also exposes every configuration byte and address register in parallel, together with a count of the entries whose match mode is not OFF. A downstream region checker uses these outputs.

Top module: `pcfg_csr_file`

## Requirements
- R1: After synchronous reset, every configuration byte and address register is zero, the active count is zero, and the drop and response-valid outputs are low.
- R2: A configuration write with index k puts byte i of the data (bits 8i+7..8i) into entry k*(XLEN/8)+i, least significant byte first. The byte is stored whole: bit 7 is the lock flag, bits [4:3] are the match mode (OFF=0, TOR=1, NA4=2, NAPOT=3), and bits [2:0] are the execute, write and read permissions, with read in bit 0.
- R3: A configuration read with index k returns entry k*(XLEN/8)+i in byte i. Bytes that map to entries past the last one read as zero.
- R4: An address write with an index below the entry count stores the full XLEN-bit word, and an address read returns it.
- R5: While an entry's lock bit (bit 7) is set, writes to its configuration byte and its address register leave them unchanged. The other bytes of the same configuration write are still stored.
- R6: An entry is also frozen when the next higher entry has its lock bit set and match mode TOR (bits [4:3] = 1). A locked neighbour in any other mode does not freeze it.
- R7: The highest entry has no neighbour and freezes only on its own lock. Writes to any index past the last entry are dropped, and address reads there return zero.
- R8: With XLEN = 64, a configuration write to an odd index is rejected entirely and changes no entry.
- R9: The active count equals the number of entries whose match mode is not OFF. It changes only after a write.
- R10: The drop output is high for exactly the one cycle after a write that lost any content, whether to a lock, a bad index or an odd index. It stays low after a write that is fully accepted.
- R11: A read raises the response-valid output in the next cycle, with the read data on the response bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_sel_addr_i | input | 1 | 0 = configuration register, 1 = address register |
| req_idx_i | input | IDX_W | Register index |
| req_wdata_i | input | XLEN | Write data |
| rsp_valid_o | output | 1 | Read response valid, one cycle after a read |
| rsp_rdata_o | output | XLEN | Read response data |
| wr_drop_o | output | 1 | One-cycle pulse after a write that lost content |
| entry_cfg_o | output | NUM_ENTRIES*8 | All configuration bytes, entry e at bits 8e+7..8e |
| entry_addr_o | output | NUM_ENTRIES*XLEN | All address registers, entry e at bits XLEN*e+XLEN-1..XLEN*e |
| active_cnt_o | output | $clog2(NUM_ENTRIES+1) | Number of entries not in mode OFF |

## Verification
The bench builds the block with XLEN = 64, 16 entries and a 6-bit index. With these values each configuration word covers eight entries, so a single write can hit an unlocked byte, a self-locked byte and a neighbour-frozen byte at once. The 64-bit width is the only one where odd configuration indices are rejected. The 6-bit index can name entries well past the sixteenth, so both the exact upper boundary and indices far beyond it are reachable.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_e;

    typedef enum logic {
        CSR_CFG  = 1'b0,
        CSR_ADDR = 1'b1
    } csr_kind_e;

    // Layout of one entry byte; lock on top, permissions at the bottom.
    typedef struct packed {
        logic       lock;
        logic [1:0] spare;
        match_e     mode;
        logic       perm_x;
        logic       perm_w;
        logic       perm_r;
    } entry_cfg_t;

    function automatic match_e cfg_mode(input logic [7:0] raw);
        entry_cfg_t c;
        c = entry_cfg_t'(raw);
        return c.mode;
    endfunction

    function automatic logic cfg_lock(input logic [7:0] raw);
        entry_cfg_t c;
        c = entry_cfg_t'(raw);
        return c.lock;
    endfunction

endpackage

// File: rtl/pcfg_lock_eval.sv
module pcfg_lock_eval
    import pcfg_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic [NUM_ENTRIES*8-1:0] cfg_flat_i,
    output logic [NUM_ENTRIES-1:0]   frozen_o
);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        if (e == NUM_ENTRIES - 1) begin : g_top
            // highest entry: only its own lock counts
            assign frozen_o[e] = cfg_lock(cfg_flat_i[e*8 +: 8]);
        end else begin : g_mid
            logic nb_tor_locked;
            assign nb_tor_locked = cfg_lock(cfg_flat_i[(e+1)*8 +: 8]) &&
                                   (cfg_mode(cfg_flat_i[(e+1)*8 +: 8]) == MATCH_TOR);
            assign frozen_o[e] = cfg_lock(cfg_flat_i[e*8 +: 8]) || nb_tor_locked;
        end
    end

endmodule

// File: rtl/pcfg_write_dec.sv
module pcfg_write_dec
    import pcfg_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 6
) (
    input  logic                     wr_en_i,
    input  csr_kind_e                kind_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic [XLEN-1:0]          wdata_i,
    input  logic [NUM_ENTRIES-1:0]   frozen_i,
    output logic [NUM_ENTRIES-1:0]   cfg_we_o,
    output logic [NUM_ENTRIES*8-1:0] cfg_wbyte_o,
    output logic [NUM_ENTRIES-1:0]   addr_we_o,
    output logic                     drop_o
);

    localparam int BYTES = XLEN / 8;

    logic misaligned;
    assign misaligned = (XLEN == 64) && idx_i[0];

    always_comb begin
        cfg_we_o    = '0;
        cfg_wbyte_o = '0;
        addr_we_o   = '0;
        drop_o      = 1'b0;
        if (wr_en_i) begin
            if (kind_i == CSR_ADDR) begin
                if (int'(idx_i) >= NUM_ENTRIES) begin
                    drop_o = 1'b1;
                end
                for (int e = 0; e < NUM_ENTRIES; e++) begin
                    if (int'(idx_i) == e) begin
                        if (frozen_i[e]) begin
                            drop_o = 1'b1;
                        end else begin
                            addr_we_o[e] = 1'b1;
                        end
                    end
                end
            end else if (misaligned) begin
                drop_o = 1'b1;
            end else begin
                for (int b = 0; b < BYTES; b++) begin
                    if (int'(idx_i) * BYTES + b >= NUM_ENTRIES) begin
                        drop_o = 1'b1;
                    end
                    for (int e = 0; e < NUM_ENTRIES; e++) begin
                        if (int'(idx_i) * BYTES + b == e) begin
                            if (frozen_i[e]) begin
                                drop_o = 1'b1;
                            end else begin
                                cfg_we_o[e]          = 1'b1;
                                cfg_wbyte_o[e*8 +: 8] = wdata_i[b*8 +: 8];
                            end
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pcfg_rd_mux.sv
module pcfg_rd_mux
    import pcfg_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 6
) (
    input  csr_kind_e                   kind_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [NUM_ENTRIES*8-1:0]    cfg_flat_i,
    input  logic [NUM_ENTRIES*XLEN-1:0] addr_flat_i,
    output logic [XLEN-1:0]             rdata_o
);

    localparam int BYTES = XLEN / 8;

    always_comb begin
        rdata_o = '0;
        if (kind_i == CSR_ADDR) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (int'(idx_i) == e) begin
                    rdata_o = addr_flat_i[e*XLEN +: XLEN];
                end
            end
        end else begin
            for (int b = 0; b < BYTES; b++) begin
                for (int e = 0; e < NUM_ENTRIES; e++) begin
                    if (int'(idx_i) * BYTES + b == e) begin
                        rdata_o[b*8 +: 8] = cfg_flat_i[e*8 +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pcfg_active_count.sv
module pcfg_active_count
    import pcfg_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
    input  logic [NUM_ENTRIES*8-1:0] cfg_flat_i,
    output logic [CNT_W-1:0]         count_o
);

    always_comb begin
        count_o = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (cfg_mode(cfg_flat_i[e*8 +: 8]) != MATCH_OFF) begin
                count_o = count_o + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pcfg_csr_file.sv
module pcfg_csr_file
    import pcfg_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 6,
    localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid_i,
    input  logic                        req_write_i,
    input  logic                        req_sel_addr_i,
    input  logic [IDX_W-1:0]            req_idx_i,
    input  logic [XLEN-1:0]             req_wdata_i,
    output logic                        rsp_valid_o,
    output logic [XLEN-1:0]             rsp_rdata_o,
    output logic                        wr_drop_o,
    output logic [NUM_ENTRIES*8-1:0]    entry_cfg_o,
    output logic [NUM_ENTRIES*XLEN-1:0] entry_addr_o,
    output logic [CNT_W-1:0]            active_cnt_o
);

    csr_kind_e                   kind;
    logic                        wr_en;
    logic [NUM_ENTRIES-1:0]      frozen;
    logic [NUM_ENTRIES-1:0]      cfg_we;
    logic [NUM_ENTRIES*8-1:0]    cfg_wbyte;
    logic [NUM_ENTRIES-1:0]      addr_we;
    logic                        drop;
    logic [XLEN-1:0]             rd_data;
    logic [NUM_ENTRIES*8-1:0]    cfg_q;
    logic [NUM_ENTRIES*XLEN-1:0] addr_q;

    assign kind  = csr_kind_e'(req_sel_addr_i);
    assign wr_en = req_valid_i && req_write_i;

    pcfg_lock_eval #(.NUM_ENTRIES(NUM_ENTRIES)) u_lock (
        .cfg_flat_i (cfg_q),
        .frozen_o   (frozen)
    );

    pcfg_write_dec #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_wdec (
        .wr_en_i     (wr_en),
        .kind_i      (kind),
        .idx_i       (req_idx_i),
        .wdata_i     (req_wdata_i),
        .frozen_i    (frozen),
        .cfg_we_o    (cfg_we),
        .cfg_wbyte_o (cfg_wbyte),
        .addr_we_o   (addr_we),
        .drop_o      (drop)
    );

    pcfg_rd_mux #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_rmux (
        .kind_i      (kind),
        .idx_i       (req_idx_i),
        .cfg_flat_i  (cfg_q),
        .addr_flat_i (addr_q),
        .rdata_o     (rd_data)
    );

    pcfg_active_count #(.NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_cnt (
        .cfg_flat_i (cfg_q),
        .count_o    (active_cnt_o)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_store
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[e*8 +: 8]       <= '0;
                addr_q[e*XLEN +: XLEN] <= '0;
            end else begin
                if (cfg_we[e]) begin
                    cfg_q[e*8 +: 8] <= cfg_wbyte[e*8 +: 8];
                end
                if (addr_we[e]) begin
                    addr_q[e*XLEN +: XLEN] <= req_wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
            wr_drop_o   <= 1'b0;
        end else begin
            rsp_valid_o <= req_valid_i && !req_write_i;
            wr_drop_o   <= drop;
            if (req_valid_i && !req_write_i) begin
                rsp_rdata_o <= rd_data;
            end
        end
    end

    assign entry_cfg_o  = cfg_q;
    assign entry_addr_o = addr_q;

endmodule

// File: rtl/pcfg_csr_file_chk.sv
module pcfg_csr_file_chk #(
    parameter int XLEN        = 64,
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 6,
    localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid_i,
    input logic                        req_write_i,
    input logic                        req_sel_addr_i,
    input logic [IDX_W-1:0]            req_idx_i,
    input logic                        rsp_valid_o,
    input logic [XLEN-1:0]             rsp_rdata_o,
    input logic                        wr_drop_o,
    input logic [NUM_ENTRIES*8-1:0]    entry_cfg_o,
    input logic [NUM_ENTRIES*XLEN-1:0] entry_addr_o,
    input logic [CNT_W-1:0]            active_cnt_o
);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        // R5
        self_lock_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            entry_cfg_o[e*8+7] |=> $stable(entry_cfg_o[e*8 +: 8]));
        // R5
        self_lock_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
            entry_cfg_o[e*8+7] |=> $stable(entry_addr_o[e*XLEN +: XLEN]));
        if (e < NUM_ENTRIES - 1) begin : g_nb
            // R6
            tor_neighbour_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (entry_cfg_o[(e+1)*8+7] && entry_cfg_o[(e+1)*8+3 +: 2] == 2'b01)
                |=> ($stable(entry_addr_o[e*XLEN +: XLEN]) && $stable(entry_cfg_o[e*8 +: 8])));
        end
    end

    // R7
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !$past(rst) && $past(req_sel_addr_i) &&
         int'($past(req_idx_i)) >= NUM_ENTRIES) |-> (rsp_rdata_o == '0));

    if (XLEN == 64) begin : g_x64
        // R8
        odd_cfg_reject_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(req_valid_i && req_write_i && !req_sel_addr_i && req_idx_i[0]))
            |-> (wr_drop_o && $stable(entry_cfg_o)));
    end

    // R9
    count_moves_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req_valid_i && req_write_i)) |-> $stable(active_cnt_o));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(active_cnt_o) <= NUM_ENTRIES);

    // R10
    drop_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_drop_o |-> (!$past(rst) && $past(req_valid_i && req_write_i)));

    // R11
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> (!$past(rst) && $past(req_valid_i && !req_write_i)));

endmodule

bind pcfg_csr_file pcfg_csr_file_chk #(
    .XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid_i    (req_valid_i),
    .req_write_i    (req_write_i),
    .req_sel_addr_i (req_sel_addr_i),
    .req_idx_i      (req_idx_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_rdata_o    (rsp_rdata_o),
    .wr_drop_o      (wr_drop_o),
    .entry_cfg_o    (entry_cfg_o),
    .entry_addr_o   (entry_addr_o),
    .active_cnt_o   (active_cnt_o)
);

// File: tb/pcfg_csr_file_bench.sv
module pcfg_csr_file_bench;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int N    = 16;
    localparam int IW   = 6;
    localparam int CW   = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic            req_sel_addr = 1'b0;
    logic [IW-1:0]   req_idx = '0;
    logic [XLEN-1:0] req_wdata = '0;
    logic            rsp_valid_o;
    logic [XLEN-1:0] rsp_rdata_o;
    logic            wr_drop_o;
    logic [N*8-1:0]  entry_cfg_o;
    logic [N*XLEN-1:0] entry_addr_o;
    logic [CW-1:0]   active_cnt_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int          due;
        bit          is_read;
        bit          exp_drop;
        logic [63:0] exp_data;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pcfg_csr_file #(.XLEN(XLEN), .NUM_ENTRIES(N), .IDX_W(IW)) u_pcfg_csr_file (
        .clk            (clk),
        .rst            (rst),
        .req_valid_i    (req_valid),
        .req_write_i    (req_write),
        .req_sel_addr_i (req_sel_addr),
        .req_idx_i      (req_idx),
        .req_wdata_i    (req_wdata),
        .rsp_valid_o    (rsp_valid_o),
        .rsp_rdata_o    (rsp_rdata_o),
        .wr_drop_o      (wr_drop_o),
        .entry_cfg_o    (entry_cfg_o),
        .entry_addr_o   (entry_addr_o),
        .active_cnt_o   (active_cnt_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cbyte(input int e);
        return entry_cfg_o[e*8 +: 8];
    endfunction

    function automatic logic [63:0] areg(input int e);
        return entry_addr_o[e*XLEN +: XLEN];
    endfunction

    task automatic do_write(input bit sel, input int idx, input logic [63:0] data,
                            input bit exp_drop, input string tag);
        exp_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel_addr = sel;
        req_idx = IW'(idx); req_wdata = data;
        it.due = cyc + 1; it.is_read = 1'b0; it.exp_drop = exp_drop;
        it.exp_data = '0; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input bit sel, input int idx, input logic [63:0] exp, input string tag);
        exp_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_sel_addr = sel; req_idx = IW'(idx);
        it.due = cyc + 1; it.is_read = 1'b1; it.exp_drop = 1'b0;
        it.exp_data = exp; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops scoreboard items in the cycle their result is due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t it;
            it = sbq.pop_front();
            if (it.due != cyc) begin
                chk(1'b0, {it.tag, " (missed slot)"}, 64'(it.due), 64'(cyc));
            end else if (it.is_read) begin
                chk(rsp_valid_o === 1'b1, {"R11 rsp_valid ", it.tag}, 64'(rsp_valid_o), 64'd1);
                chk(rsp_rdata_o === it.exp_data, it.tag, rsp_rdata_o, it.exp_data);
            end else begin
                chk(wr_drop_o === it.exp_drop, {"R10 drop ", it.tag}, 64'(wr_drop_o), 64'(it.exp_drop));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(entry_cfg_o === '0, "R1 cfg after reset", 64'(entry_cfg_o), 64'd0);
        chk(entry_addr_o === '0, "R1 addr after reset", 64'(entry_addr_o), 64'd0);
        chk(active_cnt_o === '0, "R1 count after reset", 64'(active_cnt_o), 64'd0);
        chk(wr_drop_o === 1'b0 && rsp_valid_o === 1'b0, "R1 pulses low", 64'(wr_drop_o), 64'd0);

        // R2 byte packing on write, TOR/TOR/NAPOT/NAPOT in entries 0..3
        do_write(1'b0, 0, 64'h0000_0000_1918_0B0A, 1'b0, "R2 cfg0 write accepted");
        chk(cbyte(0) === 8'h0A, "R2 entry0 byte", 64'(cbyte(0)), 64'h0A);
        chk(cbyte(1) === 8'h0B, "R2 entry1 byte", 64'(cbyte(1)), 64'h0B);
        chk(cbyte(2) === 8'h18, "R2 entry2 byte", 64'(cbyte(2)), 64'h18);
        chk(cbyte(3) === 8'h19, "R2 entry3 byte", 64'(cbyte(3)), 64'h19);
        chk(cbyte(7) === 8'h00, "R2 entry7 byte", 64'(cbyte(7)), 64'h00);
        chk(active_cnt_o === 4, "R9 count four", 64'(active_cnt_o), 64'd4);
        do_read(1'b0, 0, 64'h0000_0000_1918_0B0A, "R3 cfg0 readback");

        // R4 address register
        do_write(1'b1, 5, 64'h1234_5678_9ABC_DEF0, 1'b0, "R4 addr5 write");
        chk(areg(5) === 64'h1234_5678_9ABC_DEF0, "R4 addr5 stored", areg(5), 64'h1234_5678_9ABC_DEF0);
        do_read(1'b1, 5, 64'h1234_5678_9ABC_DEF0, "R4 addr5 readback");

        // R7 out of range indices
        do_write(1'b1, 16, 64'hFFFF, 1'b1, "R7 addr16 write dropped");
        do_write(1'b1, 40, 64'hFFFF, 1'b1, "R7 addr40 write dropped");
        do_read(1'b1, 16, 64'h0, "R7 addr16 read zero");
        do_write(1'b0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R7 cfg2 write dropped");
        do_read(1'b0, 2, 64'h0, "R3 cfg2 read past entries");
        chk(active_cnt_o === 4, "R9 count unchanged by dropped writes", 64'(active_cnt_o), 64'd4);

        // R8 odd configuration index with XLEN 64
        do_write(1'b0, 1, 64'h1111_1111_1111_1111, 1'b1, "R8 cfg1 write rejected");
        do_read(1'b0, 1, 64'h0, "R8 entries 8..15 untouched");
        chk(cbyte(0) === 8'h0A, "R8 entry0 untouched", 64'(cbyte(0)), 64'h0A);

        // R5 own lock on entry 4 (lock + NA4)
        do_write(1'b0, 0, 64'h0000_0090_1918_0B0A, 1'b0, "R5 set lock entry4");
        chk(active_cnt_o === 5, "R9 count five", 64'(active_cnt_o), 64'd5);
        do_write(1'b1, 4, 64'hDEAD, 1'b1, "R5 addr4 locked");
        chk(areg(4) === 64'h0, "R5 addr4 kept", areg(4), 64'h0);
        do_write(1'b0, 0, 64'h0, 1'b1, "R5 partial cfg write");
        chk(cbyte(4) === 8'h90, "R5 entry4 kept", 64'(cbyte(4)), 64'h90);
        chk(cbyte(0) === 8'h00 && cbyte(3) === 8'h00, "R5 other bytes stored", 64'(cbyte(3)), 64'h0);
        chk(active_cnt_o === 1, "R9 count one", 64'(active_cnt_o), 64'd1);
        do_read(1'b0, 0, 64'h0000_0090_0000_0000, "R3 cfg0 after partial write");
        // R6 negative: entry4 locked but NA4, entry3 stays writable
        do_write(1'b1, 3, 64'h33, 1'b0, "R6 addr3 not frozen by NA4 lock");
        chk(areg(3) === 64'h33, "R6 addr3 stored", areg(3), 64'h33);

        // R6 locked TOR at entry 6 freezes entry 5
        do_write(1'b0, 0, 64'h0088_0000_0000_0000, 1'b1, "R6 lock TOR entry6");
        chk(cbyte(6) === 8'h88, "R6 entry6 byte", 64'(cbyte(6)), 64'h88);
        chk(active_cnt_o === 2, "R9 count two", 64'(active_cnt_o), 64'd2);
        do_write(1'b1, 5, 64'h55, 1'b1, "R6 addr5 frozen");
        chk(areg(5) === 64'h1234_5678_9ABC_DEF0, "R6 addr5 kept", areg(5), 64'h1234_5678_9ABC_DEF0);
        do_write(1'b0, 0, 64'h0088_0500_0000_0000, 1'b1, "R6 cfg5 frozen");
        chk(cbyte(5) === 8'h00, "R6 entry5 kept", 64'(cbyte(5)), 64'h00);
        do_write(1'b1, 7, 64'h77, 1'b0, "R6 addr7 writable");
        chk(areg(7) === 64'h77, "R6 addr7 stored", areg(7), 64'h77);

        // R7 top entry boundary
        do_write(1'b1, 15, 64'hF0F0_F0F0_0F0F_0F0F, 1'b0, "R7 addr15 writable");
        do_read(1'b1, 15, 64'hF0F0_F0F0_0F0F_0F0F, "R7 addr15 readback");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "scoreboard drained", 64'(sbq.size()), 64'd0);
        finish_run();
    end

endmodule